// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

This adapter sits between a host port and a 512-byte peripheral register space in which every register has its own native width. The host issues byte, halfword or word accesses. The registers accept only accesses of their own width. A constant width map, with one entry for each 4-byte slot, tells the adapter how to reach the target register.

An access that matches the register width passes straight through. An access wider than the register is broken into a run of native accesses. A narrower read fetches the whole containing register and returns only the addressed bytes. A narrower write becomes a read, a merge and a write of the containing register. Byte order is big-endian everywhere: the lowest address holds the most significant byte.

Accesses out of range, to an empty slot, or with an illegal size code complete at once with an error flag. They reach no register.

The host raises `host_req` for one cycle while `host_busy` is low. It then waits for the one-cycle `host_done` pulse. The register side answers every native access combinationally, in the same cycle.

Top module: `mwa_adapter`

## Requirements
- R1: Slot index is offset[8:2]. A width code of 0 means empty, 1 means byte, 2 means halfword and 3 means word. In the default map, slot mod 4 gives 0 → byte, 1 → halfword, 2 → word and 3 → empty. Every native access uses its slot's width (`reg_size` 0/1/2 for 1/2/4 bytes) and is aligned to that width.
- R2: `host_size` codes are 0 for byte, 1 for halfword and 2 for word. Address bits below the access size are ignored. Host and register data sit right-aligned in the low bytes, with the lowest address as the most significant byte. `host_rdata` is zero when a write completes.
- R3: When the access size equals the native width, exactly one native access of that width is made.
- R4: An access wider than the register becomes size/width native accesses at ascending addresses. The lowest address carries the most significant part.
- R5: A read narrower than the register makes one native read of the containing register. It returns the addressed bytes: the upper byte for an even offset in a halfword, and the upper half for offset 0 mod 4 in a word.
- R6: A write narrower than the register makes one native read of the containing register, then one native write. Only the addressed bytes change.
- R7: An offset of 0x200 or more, an empty slot, or size code 3 completes with `host_err` high and `host_rdata` zero. No native access is made.
- R8: Count the request cycle as cycle 0, and let N be the number of native accesses. `host_done` pulses for exactly one cycle, in cycle N+1. `host_busy` stays high from cycle 1 through the done cycle.
- R9: A request raised while `host_busy` is high is ignored. This holds in the done cycle as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Start an access (taken only when not busy) |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| host_addr | input | ADDR_W | Byte offset into the register space |
| host_wdata | input | 32 | Write data, right-aligned |
| host_busy | output | 1 | Access in progress |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Error flag, valid with done |
| host_rdata | output | 32 | Read data, right-aligned, valid with done |
| reg_req | output | 1 | Native access strobe |
| reg_we | output | 1 | Native write enable |
| reg_size | output | 2 | Native size code (0/1/2) |
| reg_addr | output | SPACE_AW | Native byte address |
| reg_wdata | output | 32 | Native write data, right-aligned |
| reg_rdata | input | 32 | Native read data, same cycle, right-aligned |

## Verification
Two events can meet in one cycle: the completion pulse, and a fresh host request, which must be dropped because the adapter is still busy.

The bench provokes this by keeping `host_req` high through a whole split access, up to and including the done cycle. During that time it switches the request to a write of different data at another address.

The result is judged at the ports. The native access count must equal that of the first access alone. A later read of the other address must return the unchanged bytes held in the bench's shadow copy.

// File: rtl/mwa_pkg.sv
`timescale 1ns/1ps
package mwa_pkg;

    typedef enum logic [2:0] {
        K_NATIVE,
        K_SPLIT,
        K_WIDEN,
        K_RMW,
        K_ERR
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } state_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] nat_sz;     // log2 of native bytes
        logic [1:0] last_step;  // index of final native access
    } plan_t;

    // width code of a slot in the default map: 0 empty, 1 byte, 2 half, 3 word
    function automatic logic [1:0] slot_code(input int unsigned s);
        case (s % 4)
            0:       return 2'd1;
            1:       return 2'd2;
            2:       return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [31:0] byte_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // bit position of a narrow field inside a wider big-endian container
    function automatic logic [4:0] lane_shift(input logic [1:0] nat,
                                              input logic [1:0] hs,
                                              input logic [1:0] off);
        logic [3:0] b;
        b = (4'd1 << nat) - (4'd1 << hs) - {2'b00, off};
        return {b[1:0], 3'b000};
    endfunction

endpackage

// File: rtl/mwa_decode.sv
`timescale 1ns/1ps
module mwa_decode
    import mwa_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SPACE_AW = 9,
    parameter int SLOTS    = 128
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [1:0]                 size,
    input  logic                       we,
    input  logic [SLOTS-1:0][1:0]      wmap,
    output plan_t                      plan,
    output logic [SPACE_AW-1:0]        addr_al
);
    logic       in_range;
    logic [1:0] code;
    logic [1:0] ns;
    logic [2:0] hmask;

    assign in_range = (addr[ADDR_W-1:SPACE_AW] == '0);
    assign code     = wmap[addr[SPACE_AW-1:2]];
    assign ns       = code - 2'd1;
    assign hmask    = (3'd1 << size) - 3'd1;
    assign addr_al  = addr[SPACE_AW-1:0] & ~SPACE_AW'(hmask);

    always_comb begin
        plan.kind      = K_ERR;
        plan.nat_sz    = 2'd0;
        plan.last_step = 2'd0;
        if (in_range && code != 2'd0 && size != 2'd3) begin
            plan.nat_sz = ns;
            if (size == ns) begin
                plan.kind = K_NATIVE;
            end else if (size > ns) begin
                plan.kind      = K_SPLIT;
                plan.last_step = ((size - ns) == 2'd2) ? 2'd3 : 2'd1;
            end else if (we) begin
                plan.kind      = K_RMW;
                plan.last_step = 2'd1;
            end else begin
                plan.kind = K_WIDEN;
            end
        end
    end

endmodule

// File: rtl/mwa_seq.sv
`timescale 1ns/1ps
module mwa_seq
    import mwa_pkg::*;
#(
    parameter int SPACE_AW = 9
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                we,
    input  logic [1:0]          hsize,
    input  logic [31:0]         wdata,
    input  logic [SPACE_AW-1:0] addr_al,
    input  plan_t               plan,
    input  logic [31:0]         reg_rdata,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [31:0]         rdata,
    output logic                reg_req,
    output logic                reg_we,
    output logic [1:0]          reg_size,
    output logic [SPACE_AW-1:0] reg_addr,
    output logic [31:0]         reg_wdata
);
    state_e              st;
    kind_e               kind_q;
    logic [1:0]          nat_q, hs_q, last_q, step_q;
    logic [SPACE_AW-1:0] addr_q;
    logic                we_q, err_q;
    logic [31:0]         wdata_q, acc_q, hold_q;

    logic [2:0]          nmask;
    logic [1:0]          off;
    logic [SPACE_AW-1:0] base;
    logic [4:0]          lsh, ssh;
    logic [31:0]         rd, hmsk;

    assign nmask = (3'd1 << nat_q) - 3'd1;
    assign off   = addr_q[1:0] & nmask[1:0];
    assign base  = addr_q - SPACE_AW'(off);
    assign lsh   = lane_shift(nat_q, hs_q, off);
    assign ssh   = {(last_q - step_q), 3'b000} << nat_q;
    assign rd    = reg_rdata & byte_mask(nat_q);
    assign hmsk  = byte_mask(hs_q);

    always_comb begin
        reg_req   = (st == ST_RUN);
        reg_size  = nat_q;
        reg_addr  = addr_q;
        reg_we    = we_q;
        reg_wdata = wdata_q & byte_mask(nat_q);
        case (kind_q)
            K_SPLIT: begin
                reg_addr  = addr_q + (SPACE_AW'(step_q) << nat_q);
                reg_wdata = (wdata_q >> ssh) & byte_mask(nat_q);
            end
            K_WIDEN: begin
                reg_addr = base;
                reg_we   = 1'b0;
            end
            K_RMW: begin
                reg_addr  = base;
                reg_we    = (step_q == 2'd1);
                reg_wdata = (hold_q & ~(hmsk << lsh)) | ((wdata_q & hmsk) << lsh);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            kind_q  <= K_ERR;
            nat_q   <= 2'd0;
            hs_q    <= 2'd0;
            last_q  <= 2'd0;
            step_q  <= 2'd0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            wdata_q <= '0;
            acc_q   <= '0;
            hold_q  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req) begin
                    kind_q  <= plan.kind;
                    nat_q   <= plan.nat_sz;
                    last_q  <= plan.last_step;
                    hs_q    <= hsize;
                    addr_q  <= addr_al;
                    we_q    <= we;
                    wdata_q <= wdata;
                    step_q  <= 2'd0;
                    acc_q   <= '0;
                    err_q   <= (plan.kind == K_ERR);
                    st      <= (plan.kind == K_ERR) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    case (kind_q)
                        K_NATIVE: if (!we_q) acc_q <= rd;
                        K_SPLIT:  if (!we_q) acc_q <= (acc_q << (6'd8 << nat_q)) | rd;
                        K_WIDEN:  acc_q <= (rd >> lsh) & hmsk;
                        K_RMW:    if (step_q == 2'd0) hold_q <= rd;
                        default: ;
                    endcase
                    step_q <= step_q + 2'd1;
                    if (step_q == last_q) st <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (st != ST_IDLE);
    assign done  = (st == ST_FIN);
    assign err   = done & err_q;
    assign rdata = done ? acc_q : '0;

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst) (req && !busy) |=> busy);
    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (rst) err |-> (rdata == '0));
    // R7
    err_silent_chk: assert property (@(posedge clk) disable iff (rst) err |-> !$past(reg_req));

endmodule

// File: rtl/mwa_adapter.sv
`timescale 1ns/1ps
module mwa_adapter
    import mwa_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SPACE_BYTES = 512
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           host_req,
    input  logic                           host_we,
    input  logic [1:0]                     host_size,
    input  logic [ADDR_W-1:0]              host_addr,
    input  logic [31:0]                    host_wdata,
    output logic                           host_busy,
    output logic                           host_done,
    output logic                           host_err,
    output logic [31:0]                    host_rdata,
    output logic                           reg_req,
    output logic                           reg_we,
    output logic [1:0]                     reg_size,
    output logic [$clog2(SPACE_BYTES)-1:0] reg_addr,
    output logic [31:0]                    reg_wdata,
    input  logic [31:0]                    reg_rdata
);
    localparam int SPACE_AW = $clog2(SPACE_BYTES);
    localparam int SLOTS    = SPACE_BYTES / 4;

    logic [SLOTS-1:0][1:0] wmap;
    plan_t                 plan;
    logic [SPACE_AW-1:0]   addr_al;

    for (genvar g = 0; g < SLOTS; g++) begin : g_map
        assign wmap[g] = slot_code(g);
    end

    mwa_decode #(.ADDR_W(ADDR_W), .SPACE_AW(SPACE_AW), .SLOTS(SLOTS)) dec_i (
        .addr    (host_addr),
        .size    (host_size),
        .we      (host_we),
        .wmap    (wmap),
        .plan    (plan),
        .addr_al (addr_al)
    );

    mwa_seq #(.SPACE_AW(SPACE_AW)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .req       (host_req),
        .we        (host_we),
        .hsize     (host_size),
        .wdata     (host_wdata),
        .addr_al   (addr_al),
        .plan      (plan),
        .reg_rdata (reg_rdata),
        .busy      (host_busy),
        .done      (host_done),
        .err       (host_err),
        .rdata     (host_rdata),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_size  (reg_size),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata)
    );

    // R1
    native_size_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> (reg_size == wmap[reg_addr[SPACE_AW-1:2]] - 2'd1));
    // R1
    native_align_chk: assert property (@(posedge clk) disable iff (rst)
        reg_req |-> ((reg_addr[1:0] & ((2'd1 << reg_size) - 2'd1)) == 2'd0));

endmodule

// File: tb/mwa_adapter_tb_top.sv
`timescale 1ns/1ps
module mwa_adapter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [1:0]  host_size = 2'd0;
    logic [11:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_busy, host_done, host_err;
    logic [31:0] host_rdata;
    logic        reg_req, reg_we;
    logic [1:0]  reg_size;
    logic [8:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;

    int checks = 0, errors = 0;
    int nat_cnt = 0, nat_bad = 0;
    logic [7:0] regs   [512];
    logic [7:0] shadow [512];

    always #2.5 clk = ~clk;

    mwa_adapter dut_i (.*);

    function automatic int slot_bytes(input int a);
        case ((a >> 2) % 4)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_err(input int sz, input int a);
        return (a >= 512) || (sz == 3) || (slot_bytes(a) == 0);
    endfunction

    function automatic int exp_steps(input bit w, input int sz, input int a);
        int s, wb;
        if (is_err(sz, a)) return 0;
        s = 1 << sz; wb = slot_bytes(a);
        if (s == wb) return 1;
        if (s > wb) return s / wb;
        return w ? 2 : 1;
    endfunction

    function automatic string cls_tag(input bit w, input int sz, input int a);
        int s, wb;
        if (is_err(sz, a)) return "R7";
        s = 1 << sz; wb = slot_bytes(a);
        if (s == wb) return "R3";
        if (s > wb) return "R4";
        return w ? "R6" : "R5";
    endfunction

    // register model: same-cycle big-endian read, write on the edge
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < 4; k++)
            if (k < (1 << reg_size))
                reg_rdata = {reg_rdata[23:0], regs[(int'(reg_addr) + k) % 512]};
    end

    always @(posedge clk) begin
        if (!rst && reg_req) begin
            nat_cnt++;
            if ((1 << reg_size) != slot_bytes(int'(reg_addr)) ||
                (int'(reg_addr) % (1 << reg_size)) != 0)
                nat_bad++;
            if (reg_we)
                for (int k = 0; k < 4; k++)
                    if (k < (1 << reg_size))
                        regs[(int'(reg_addr) + k) % 512] <=
                            8'(reg_wdata >> (((1 << reg_size) - 1 - k) * 8));
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input bit w, input int sz, input int a, input logic [31:0] d,
                          input bit hold, input string dtag, output logic [31:0] got);
        int k, s, al, en;
        bit ee;
        logic [31:0] er;
        string ct;
        ee = is_err(sz, a);
        en = exp_steps(w, sz, a);
        ct = hold ? "R9" : cls_tag(w, sz, a);
        s  = (sz == 3) ? 1 : (1 << sz);
        al = a & ~(s - 1);
        er = '0;
        if (!w && !ee)
            for (int i = 0; i < s; i++) er = {er[23:0], shadow[al + i]};
        nat_cnt = 0; nat_bad = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_size = 2'(sz);
        host_addr = 12'(a); host_wdata = d;
        @(negedge clk);
        if (hold) begin
            host_we = 1'b1; host_size = 2'd0; host_addr = 12'h000;
            host_wdata = {24'h0, ~shadow[0]};
        end else host_req = 1'b0;
        check(host_busy == 1'b1, "R8", host_busy, 1);
        k = 1;
        while (!host_done && k < 50) begin @(negedge clk); k++; end
        got = host_rdata;
        check(host_err == ee, "R7", host_err, ee);
        check(host_rdata == (w ? 32'h0 : er), w ? "R2" : dtag, host_rdata, w ? 0 : er);
        check(nat_cnt == en, ct, nat_cnt, en);
        check(k == en + 1, "R8", k, en + 1);
        check(nat_bad == 0, "R1", nat_bad, 0);
        host_req = 1'b0;
        @(negedge clk);
        check(!host_done && !host_busy, "R8", {host_done, host_busy}, 0);
        if (w && !ee)
            for (int i = 0; i < s; i++) shadow[al + i] = 8'(d >> ((s - 1 - i) * 8));
    endtask

    initial begin
        #(100000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] g;
        int unsigned seed;
        seed = $urandom(32'h00C0FFEE);
        for (int i = 0; i < 512; i++) begin
            regs[i] = 8'($urandom);
            shadow[i] = regs[i];
        end
        repeat (3) @(negedge clk);
        check(!host_busy && !host_done && !reg_req, "R8", {host_busy, host_done, reg_req}, 0);
        rst = 1'b0;
        @(negedge clk);

        // directed corners
        run_op(0, 0, 12'h004, 0, 0, "R5", g);          // even byte of halfword
        run_op(0, 0, 12'h005, 0, 0, "R5", g);          // odd byte of halfword
        run_op(0, 1, 12'h00A, 0, 0, "R5", g);          // lower half of word
        run_op(0, 0, 12'h00B, 0, 0, "R5", g);          // last byte of word
        run_op(1, 0, 12'h015, 32'hA5, 0, "R6", g);     // byte into halfword
        run_op(0, 1, 12'h014, 0, 0, "R6", g);
        run_op(1, 1, 12'h018, 32'h1234, 0, "R6", g);   // upper half of word
        run_op(1, 1, 12'h01A, 32'h5678, 0, "R6", g);
        run_op(0, 2, 12'h018, 0, 0, "R6", g);
        run_op(1, 2, 12'h020, 32'hDEADBEEF, 0, "R4", g); // word into bytes
        run_op(0, 2, 12'h020, 0, 0, "R4", g);
        run_op(0, 1, 12'h021, 0, 0, "R2", g);          // low bit ignored
        run_op(1, 2, 12'h024, 32'hCAFEF00D, 0, "R4", g); // word into halves
        run_op(0, 2, 12'h024, 0, 0, "R4", g);
        run_op(0, 2, 12'h028, 0, 0, "R3", g);
        run_op(0, 2, 12'h200, 0, 0, "R7", g);          // out of range
        run_op(1, 0, 12'h00C, 32'hFF, 0, "R7", g);     // empty slot
        run_op(0, 3, 12'h008, 0, 0, "R7", g);          // illegal size
        run_op(0, 2, 12'h030, 0, 1, "R9", g);          // request held through done
        run_op(0, 2, 12'h000, 0, 0, "R9", g);

        for (int n = 0; n < 400; n++) begin
            int r, sz, a;
            bit w;
            r  = int'($urandom % 16);
            sz = (r == 15) ? 3 : r % 3;
            a  = int'($urandom % 600);
            w  = 1'($urandom);
            run_op(w, sz, a, $urandom, (n % 37) == 5, cls_tag(w, sz, a), g);
        end
        for (int a = 0; a < 512; a += 4)
            if (slot_bytes(a) != 0) run_op(0, 2, a, 0, 0, "R2", g);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule